// File: doc/BRIEF.md
# Coarse/Fine Programmable Clock Divider

This block divides a fast clock by a programmable ratio set by two 8-bit values: a coarse target and a fine target. A dual-modulus prescaler divides the fast clock by 32 or 33 and produces a one-cycle tick. Each tick advances an 8-bit up-counter. A single equality comparator is steered between the two targets by a target-select flag. The first match in each loop is the fine match. It switches the prescaler to divide-by-32 and hands the comparator to the coarse target. The second match is the coarse match. It restarts the counter, switches the prescaler to divide-by-33 and hands the comparator back to the fine target.

A divide-by-2 stage toggles on every match from the shared comparator, so the output completes one period per counter loop. All logic runs on the fast clock, and the prescaler tick serves as a clock enable. An illegal configuration (coarse target zero, or fine target not below coarse) raises an error flag. While the flag is up, the datapath is held at its restart state and the output stays low. When the configuration becomes legal, division starts again from that restart state. All pins are plain level signals; the block has no data stream and no handshake.

Top module: `pdiv_cf_top`

## Requirements
- R1: After reset `clk_out`, `fine_stb` and `coarse_stb` are 0 and `mod_sel` is 1 (divide-by-33 selected).
- R2: The prescaler period is 33 fast cycles while `mod_sel` is 1 and 32 while it is 0. `mod_sel` changes only on a prescaler wrap. Each match strobe stays high for exactly one prescaler period: 32 cycles for `fine_stb` and 33 for `coarse_stb`.
- R3: With legal inputs C = `coarse_val` and F = `fine_val`, the period of `clk_out` is 32*(C+1) + F + 1 fast cycles, measured rising edge to rising edge. Example: C=14, F=4 gives 485.
- R4: `clk_out` is high for 32*(C-F) fast cycles and low for 33*(F+1) fast cycles in each period.
- R5: A fine match (counter equals F while the fine target is selected) raises `clk_out`, pulses `fine_stb`, clears `mod_sel` and selects the coarse target. The two strobes are never high together.
- R6: A coarse match (counter equals C while the coarse target is selected) lowers `clk_out`, pulses `coarse_stb`, sets `mod_sel`, restarts the counter at 0 and selects the fine target.
- R7: `cfg_err` is 1 exactly when C is 0 or F >= C, delayed by one register stage. While it is 1, `clk_out`, `fine_stb` and `coarse_stb` are 0 and `mod_sel` is 1.
- R8: Counting from the first sampled cycle after `cfg_err` falls, the first rising edge of `clk_out` arrives after 33*(F+1) fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_val | input | 8 | Coarse target C |
| fine_val | input | 8 | Fine target F, must be below C |
| clk_out | output | 1 | Divided output clock |
| fine_stb | output | 1 | High for one prescaler period after a fine match |
| coarse_stb | output | 1 | High for one prescaler period after a coarse match |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide-by-33, 0 = divide-by-32 |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The hardest case is a mode switch that lands exactly on a prescaler wrap while the comparator is also being handed to the other target. This happens at the extreme settings F=0, where the fine match falls on the first tick after restart, and C=F+1, where the coarse match follows the fine match on the very next tick. Both settings are driven directly. Random legal pairs are added, and each case enters from the error state, so the first-edge latency after restart is measured in every case. Illegal pairs are applied between cases to check that the output is held low.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  typedef enum logic {
    SEL_FINE   = 1'b0,
    SEL_COARSE = 1'b1
  } tgt_e;

  function automatic tgt_e tgt_flip(input tgt_e t);
    return (t == SEL_FINE) ? SEL_COARSE : SEL_FINE;
  endfunction
endpackage

// File: rtl/pdiv_prescaler.sv
module pdiv_prescaler #(
  parameter int BASE = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode,
  output logic tick
);
  localparam int PW = $clog2(BASE + 1);
  localparam logic [PW-1:0] TERM_LO = PW'(BASE - 1);
  localparam logic [PW-1:0] TERM_HI = PW'(BASE);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] term;

  // mode only changes on the edge where pcnt wraps, so a period is never cut short
  assign term = mode ? TERM_HI : TERM_LO;
  assign tick = (pcnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clr)   pcnt <= '0;
    else if (tick)  pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pdiv_steer.sv
module pdiv_steer
  import pdiv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] cr,
  input  logic [CNT_W-1:0] fr,
  output logic             mode,
  output logic             hit,
  output logic             fine_stb,
  output logic             coarse_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  tgt_e             sel;
  logic             eq;
  logic             fine_hit;
  logic             coarse_hit;

  // one comparator, shared between the two targets
  assign target     = (sel == SEL_COARSE) ? cr : fr;
  assign eq         = (cnt == target);
  assign hit        = tick & eq;
  assign fine_hit   = hit & (sel == SEL_FINE);
  assign coarse_hit = hit & (sel == SEL_COARSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sel        <= SEL_FINE;
      mode       <= 1'b1;
      fine_stb   <= 1'b0;
      coarse_stb <= 1'b0;
    end else if (clr) begin
      cnt        <= '0;
      sel        <= SEL_FINE;
      mode       <= 1'b1;
      fine_stb   <= 1'b0;
      coarse_stb <= 1'b0;
    end else if (tick) begin
      fine_stb   <= fine_hit;
      coarse_stb <= coarse_hit;
      if (hit) sel <= tgt_flip(sel);
      if (coarse_hit) begin
        cnt  <= '0;
        mode <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (fine_hit) mode <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdiv_toggle.sv
module pdiv_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pulse,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (clr)    q <= 1'b0;
    else if (pulse)  q <= ~q;
  end
endmodule

// File: rtl/pdiv_cf_top.sv
module pdiv_cf_top #(
  parameter int CNT_W    = 8,
  parameter int PRE_BASE = 32
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] coarse_val,
  input  logic [CNT_W-1:0] fine_val,
  output logic             clk_out,
  output logic             fine_stb,
  output logic             coarse_stb,
  output logic             mod_sel,
  output logic             cfg_err
);
  logic cfg_bad;
  logic err_q;
  logic pre_tick;
  logic eq_pulse;

  assign cfg_bad = (coarse_val == '0) || (fine_val >= coarse_val);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cfg_bad;
  end

  pdiv_prescaler #(.BASE(PRE_BASE)) u_pre (
    .clk  (clk_in),
    .rst_n(rst_n),
    .clr  (err_q),
    .mode (mod_sel),
    .tick (pre_tick)
  );

  pdiv_steer #(.CNT_W(CNT_W)) u_steer (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .clr       (err_q),
    .tick      (pre_tick),
    .cr        (coarse_val),
    .fr        (fine_val),
    .mode      (mod_sel),
    .hit       (eq_pulse),
    .fine_stb  (fine_stb),
    .coarse_stb(coarse_stb)
  );

  pdiv_toggle u_div2 (
    .clk  (clk_in),
    .rst_n(rst_n),
    .clr  (err_q),
    .pulse(eq_pulse),
    .q    (clk_out)
  );

  assign cfg_err = err_q;
endmodule

// File: rtl/pdiv_cf_chk.sv
module pdiv_cf_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mode,
  input logic fine_stb,
  input logic coarse_stb,
  input logic clk_out,
  input logic cfg_err
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fine_stb && coarse_stb)); // R5

  AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode) && !$past(cfg_err)) |-> $past(tick)); // R2

  AST_RISE_ON_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> ($rose(fine_stb) && !mode)); // R5

  AST_FALL_ON_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_out) && !$past(cfg_err)) |-> ($rose(coarse_stb) && mode)); // R6

  AST_ERR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!clk_out && !fine_stb && !coarse_stb)); // R7
endmodule

bind pdiv_cf_top pdiv_cf_chk u_chk (
  .clk       (clk_in),
  .rst_n     (rst_n),
  .tick      (pre_tick),
  .mode      (mod_sel),
  .fine_stb  (fine_stb),
  .coarse_stb(coarse_stb),
  .clk_out   (clk_out),
  .cfg_err   (cfg_err)
);

// File: tb/pdiv_cf_top_tb.sv
`timescale 1ns/1ps
module pdiv_cf_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cr_i = 8'd14;
  logic [7:0] fr_i = 8'd4;
  logic       clk_out, fine_stb, coarse_stb, mod_sel, cfg_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  localparam int WATCHDOG = 190000;
  localparam int GUARD = 20000;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdiv_cf_top u_dut (
    .clk_in(clk), .rst_n(rst_n), .coarse_val(cr_i), .fine_val(fr_i),
    .clk_out(clk_out), .fine_stb(fine_stb), .coarse_stb(coarse_stb),
    .mod_sel(mod_sel), .cfg_err(cfg_err)
  );

  function automatic int exp_period(int c, int f); return 32*(c+1) + f + 1; endfunction
  function automatic int exp_high(int c, int f);   return 32*(c-f);         endfunction
  function automatic int exp_low(int f);           return 33*(f+1);         endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_err(input int c, input int f);
    int seen_high = 0;
    cr_i = 8'(c); fr_i = 8'(f);
    repeat (3) @(negedge clk);
    check("R7 err flag", int'(cfg_err), 1);
    check("R7 outputs quiet", int'({clk_out, fine_stb, coarse_stb, mod_sel}), 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clk_out) seen_high++;
    end
    check("R7 out held low", seen_high, 0);
  endtask

  task automatic run_case(input int c, input int f);
    int n = 0, h = 0, l = 0, fcnt = 0, ccnt = 0, mism = 0;
    cr_i = 8'd0; fr_i = 8'd0;
    repeat (4) @(negedge clk);
    check("R7 err on C=0", int'(cfg_err), 1);
    cr_i = 8'(c); fr_i = 8'(f);
    @(negedge clk);
    check("R7 err cleared", int'(cfg_err), 0);
    while (!clk_out && n < GUARD) begin @(negedge clk); n++; end
    check($sformatf("R8 first rise C=%0d F=%0d", c, f), n, exp_low(f));
    check("R5 fine strobe and mode at rise", int'({fine_stb, coarse_stb, mod_sel}), 4);
    while (clk_out && h < GUARD) begin
      if (fine_stb) fcnt++;
      if (mod_sel == clk_out) mism++;
      h++; @(negedge clk);
    end
    check($sformatf("R6 coarse strobe and mode at fall C=%0d", c), int'({fine_stb, coarse_stb, mod_sel}), 3);
    while (!clk_out && l < GUARD) begin
      if (coarse_stb) ccnt++;
      if (mod_sel == clk_out) mism++;
      l++; @(negedge clk);
    end
    check($sformatf("R4 high C=%0d F=%0d", c, f), h, exp_high(c, f));
    check($sformatf("R4 low C=%0d F=%0d", c, f), l, exp_low(f));
    check($sformatf("R3 period C=%0d F=%0d", c, f), h + l, exp_period(c, f));
    check("R2 fine strobe width", fcnt, 32);
    check("R2 coarse strobe width", ccnt, 33);
    check("R5 R6 mode tracks output phase", mism, 0);
  endtask

  initial begin
    #(WATCHDOG * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 clk_out reset", int'(clk_out), 0);
    check("R1 strobes reset", int'({fine_stb, coarse_stb}), 0);
    check("R1 mod_sel reset", int'(mod_sel), 1);
    check("R1 cfg_err reset", int'(cfg_err), 0);

    run_case(14, 4);
    run_case(1, 0);
    run_case(2, 1);
    run_case(9, 0);
    run_case(255, 254);
    run_err(5, 5);
    run_err(3, 200);
    run_case(200, 0);
    for (int k = 0; k < 8; k++) begin
      int c, f;
      c = int'($urandom_range(47, 1));
      f = int'($urandom_range(c - 1, 0));
      run_case(c, f);
    end
    finish_run();
  end
endmodule